// File: doc/BRIEF.md
# Gated Physical Counter Offset Register

This block holds a 64-bit offset that is subtracted from a free-running system count to form the physical count seen by the two lowest privilege levels. Software reaches the offset through a system-register access port. Each request carries a 16-bit instruction encoding, the requester's exception level, a read/write flag and write data. The block also samples six control inputs: whether level 2 is enabled, whether level 3 is present, whether level 3 runs in 32-bit state, a monitor permission bit, a nesting enable bit and a nesting-to-memory bit.

A two-state controller handles the requests. In `ST_IDLE` a request strobe latches the request and the control inputs, and the controller moves to `ST_RESP` (transition IDLE_TO_RESP). It spends exactly one cycle in `ST_RESP`, presenting a one-hot outcome with an exception class, read data and redirect information. It then always returns to `ST_IDLE` (transition RESP_TO_IDLE). If the outcome is a direct access and the request is a write, the offset is updated on that same edge. Strobes that arrive while the controller is in `ST_RESP` are dropped.

The outcome comes from a prioritised decision at each level. It can mark the access as undefined, trap it to level 2 or level 3, redirect it to a fixed memory slot, or let it act on the register.

Top module: `ctr_offset_gate`

## Requirements
- R1: The request encoding is packed as {op0[1:0], op1[2:0], CRn[3:0], CRm[3:0], op2[2:0]}. Only 16'hE706 matches. Any other value still raises `resp_valid`, but with an all-zero outcome, zero exception class and no register write.
- R2: A matching request with `req_el` = 0 gives the UNDEF outcome.
- R3: For a matching request with `req_el` = 1, when `l2_enabled`, `nest_en` and `nest_mem` are all high, the outcome is REDIRECT. `redir_slot` is 12'h1A8, and on a write `redir_we` is high with `redir_wdata` equal to the write data.
- R4: For a matching request with `req_el` = 1, when `l2_enabled` and `nest_en` are high and `nest_mem` is low, the outcome is TRAP_L2 with exception class 6'h18. Every other level-1 case is UNDEF.
- R5: For a matching request with `req_el` = 2, when `l3_present` is high, `l3_narrow` is low and `mon_allow` is low, the outcome is TRAP_L3 with exception class 6'h18. Otherwise the outcome is ACCESS.
- R6: A matching request with `req_el` = 3 always gives ACCESS.
- R7: `resp_outcome` is one-hot with bit 0 UNDEF, bit 1 TRAP_L2, bit 2 TRAP_L3, bit 3 REDIRECT and bit 4 ACCESS. `resp_valid` is high for exactly one cycle, the cycle after the accepted strobe. A strobe that arrives while `resp_valid` is high is ignored.
- R8: A write with the ACCESS outcome loads the offset on the clock edge that ends the response cycle. No other request changes the offset.
- R9: `resp_rdata` equals the current offset when the outcome is ACCESS and is zero otherwise. `resp_ec` is zero for every outcome other than the two traps.
- R10: `phys_count` equals `free_count` minus the offset, modulo 2^64. When `offset_off` is high, `phys_count` equals `free_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the controller (the offset itself has no reset) |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_enc | input | 16 | Packed instruction encoding |
| req_el | input | 2 | Requester exception level |
| req_wdata | input | 64 | Write operand |
| l2_enabled | input | 1 | Level 2 enabled in the current state |
| l3_present | input | 1 | Level 3 implemented |
| l3_narrow | input | 1 | Level 3 runs in 32-bit state |
| mon_allow | input | 1 | Monitor permission for level-2 access |
| nest_en | input | 1 | Nesting trap enable |
| nest_mem | input | 1 | Nesting redirect-to-memory enable |
| free_count | input | 64 | Free-running system count |
| offset_off | input | 1 | Bypass the offset |
| resp_valid | output | 1 | Response cycle marker |
| resp_outcome | output | 5 | One-hot outcome |
| resp_ec | output | 6 | Exception class for traps |
| resp_rdata | output | 64 | Read data |
| redir_slot | output | 12 | Memory slot offset on redirect |
| redir_we | output | 1 | Redirected write strobe |
| redir_wdata | output | 64 | Redirected write data |
| phys_count | output | 64 | Offset-corrected count |

## Verification
The bench targets the level-1 case where `nest_mem` is high and `nest_en` is low. A design that checked the memory bit alone would redirect here instead of returning UNDEF. It also covers level 2 with level 3 present but running in 32-bit state, where a design that skipped the state check would trap instead of granting access. Writes that trap, redirect or fail to match are followed by offset reads and a look at `phys_count`, which would expose a design that writes on any matching request. A strobe held high through the response cycle would show up as a second response if the design accepted requests while busy. Counts smaller than the offset check the modulo wrap of the subtraction.

// File: rtl/ctr_offset_pkg.sv
package ctr_offset_pkg;
    localparam int DATA_W   = 64;
    localparam int ENC_W    = 16;
    localparam int EC_W     = 6;
    localparam int SLOT_W   = 12;
    localparam int OUT_W    = 5;

    typedef enum logic [OUT_W-1:0] {
        OUT_NONE   = 5'b00000,
        OUT_UNDEF  = 5'b00001,
        OUT_TRAP2  = 5'b00010,
        OUT_TRAP3  = 5'b00100,
        OUT_REDIR  = 5'b01000,
        OUT_ACCESS = 5'b10000
    } outcome_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } state_e;

    typedef struct packed {
        logic l2_en;
        logic l3_present;
        logic l3_narrow;
        logic mon_allow;
        logic nest_en;
        logic nest_mem;
    } ctl_t;
endpackage

// File: rtl/access_gate.sv
module access_gate
    import ctr_offset_pkg::*;
#(
    parameter logic [ENC_W-1:0] MATCH_ENC = 16'hE706,
    parameter logic [EC_W-1:0]  TRAP_EC   = 6'h18
) (
    input  logic [ENC_W-1:0] enc,
    input  logic [1:0]       el,
    input  ctl_t             ctl,
    output outcome_e         outcome,
    output logic [EC_W-1:0]  ec
);
    always_comb begin
        outcome = OUT_NONE;
        if (enc == MATCH_ENC) begin
            unique case (el)
                2'd0: outcome = OUT_UNDEF;
                2'd1: begin
                    if (ctl.l2_en && ctl.nest_en && ctl.nest_mem)
                        outcome = OUT_REDIR;
                    else if (ctl.l2_en && ctl.nest_en)
                        outcome = OUT_TRAP2;
                    else
                        outcome = OUT_UNDEF;
                end
                2'd2: begin
                    if (ctl.l3_present && !ctl.l3_narrow && !ctl.mon_allow)
                        outcome = OUT_TRAP3;
                    else
                        outcome = OUT_ACCESS;
                end
                default: outcome = OUT_ACCESS;
            endcase
        end
        ec = (outcome == OUT_TRAP2 || outcome == OUT_TRAP3) ? TRAP_EC : '0;
    end
endmodule

// File: rtl/offset_store.sv
module offset_store
    import ctr_offset_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] free_count,
    input  logic              offset_off,
    output logic [DATA_W-1:0] offset,
    output logic [DATA_W-1:0] phys_count
);
    // The offset has no defined reset value; software loads it.
    always_ff @(posedge clk) begin
        if (wr_en)
            offset <= wr_data;
    end

    always_comb begin
        phys_count = offset_off ? free_count : (free_count - offset);
    end

    assert_write_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> offset == $past(wr_data));
    assert_hold_without_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(offset));
    assert_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        offset_off |-> phys_count == free_count);
endmodule

// File: rtl/ctr_offset_gate.sv
module ctr_offset_gate
    import ctr_offset_pkg::*;
#(
    parameter logic [SLOT_W-1:0] SLOT_ADDR = 12'h1A8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [15:0]       req_enc,
    input  logic [1:0]        req_el,
    input  logic [63:0]       req_wdata,
    input  logic              l2_enabled,
    input  logic              l3_present,
    input  logic              l3_narrow,
    input  logic              mon_allow,
    input  logic              nest_en,
    input  logic              nest_mem,
    input  logic [63:0]       free_count,
    input  logic              offset_off,
    output logic              resp_valid,
    output logic [4:0]        resp_outcome,
    output logic [5:0]        resp_ec,
    output logic [63:0]       resp_rdata,
    output logic [11:0]       redir_slot,
    output logic              redir_we,
    output logic [63:0]       redir_wdata,
    output logic [63:0]       phys_count
);
    state_e            state, state_nx;
    logic [ENC_W-1:0]  lat_enc;
    logic [1:0]        lat_el;
    logic              lat_write;
    logic [DATA_W-1:0] lat_wdata;
    ctl_t              lat_ctl;
    outcome_e          gate_out;
    logic [EC_W-1:0]   gate_ec;
    logic [DATA_W-1:0] offset;
    logic              commit;

    // Next-state logic: IDLE_TO_RESP on a strobe, RESP_TO_IDLE always.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_RESP;
            ST_RESP: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lat_enc   <= '0;
            lat_el    <= '0;
            lat_write <= 1'b0;
            lat_wdata <= '0;
            lat_ctl   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && req_valid) begin
                lat_enc   <= req_enc;
                lat_el    <= req_el;
                lat_write <= req_write;
                lat_wdata <= req_wdata;
                lat_ctl   <= '{l2_en: l2_enabled, l3_present: l3_present,
                               l3_narrow: l3_narrow, mon_allow: mon_allow,
                               nest_en: nest_en, nest_mem: nest_mem};
            end
        end
    end

    access_gate u_gate (
        .enc     (lat_enc),
        .el      (lat_el),
        .ctl     (lat_ctl),
        .outcome (gate_out),
        .ec      (gate_ec)
    );

    // Output process.
    always_comb begin
        resp_valid   = 1'b0;
        resp_outcome = '0;
        resp_ec      = '0;
        resp_rdata   = '0;
        redir_slot   = '0;
        redir_we     = 1'b0;
        redir_wdata  = '0;
        commit       = 1'b0;
        unique case (state)
            ST_RESP: begin
                resp_valid   = 1'b1;
                resp_outcome = gate_out;
                resp_ec      = gate_ec;
                if (gate_out == OUT_ACCESS) begin
                    resp_rdata = offset;
                    commit     = lat_write;
                end
                if (gate_out == OUT_REDIR) begin
                    redir_slot = SLOT_ADDR;
                    redir_we   = lat_write;
                    if (lat_write) redir_wdata = lat_wdata;
                end
            end
            default: ;
        endcase
    end

    offset_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (commit),
        .wr_data    (lat_wdata),
        .free_count (free_count),
        .offset_off (offset_off),
        .offset     (offset),
        .phys_count (phys_count)
    );

    assert_outcome_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(resp_outcome));
    assert_single_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
    assert_resp_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!resp_valid && req_valid) |=> resp_valid);
    assert_level0_undef_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && lat_el == 2'd0 && resp_outcome != 5'b0) |-> resp_outcome == 5'b00001);
    assert_level3_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && lat_el == 2'd3 && resp_outcome != 5'b0) |-> resp_outcome == 5'b10000);
    assert_trap_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_outcome[1] || resp_outcome[2]) |-> resp_ec == 6'h18);
    assert_ec_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_outcome[1] || resp_outcome[2]) |-> resp_ec == 6'h0);
endmodule

// File: tb/ctr_offset_gate_bench.sv
module ctr_offset_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_enc = '0;
    logic [1:0]  req_el = '0;
    logic [63:0] req_wdata = '0;
    logic        l2_enabled = 0, l3_present = 0, l3_narrow = 0, mon_allow = 0, nest_en = 0, nest_mem = 0;
    logic [63:0] free_count = '0;
    logic        offset_off = 1'b0;
    logic        resp_valid, redir_we;
    logic [4:0]  resp_outcome;
    logic [5:0]  resp_ec;
    logic [63:0] resp_rdata, redir_wdata, phys_count;
    logic [11:0] redir_slot;

    int tests = 0, fails = 0;
    logic [63:0] model_off;
    logic        model_known = 1'b0;

    always #5 clk = ~clk;

    ctr_offset_gate u_ctr_offset_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_enc(req_enc), .req_el(req_el), .req_wdata(req_wdata),
        .l2_enabled(l2_enabled), .l3_present(l3_present), .l3_narrow(l3_narrow),
        .mon_allow(mon_allow), .nest_en(nest_en), .nest_mem(nest_mem),
        .free_count(free_count), .offset_off(offset_off),
        .resp_valid(resp_valid), .resp_outcome(resp_outcome), .resp_ec(resp_ec),
        .resp_rdata(resp_rdata), .redir_slot(redir_slot), .redir_we(redir_we),
        .redir_wdata(redir_wdata), .phys_count(phys_count)
    );

    function automatic logic [4:0] exp_out(logic [15:0] enc, logic [1:0] el, logic l2,
                                           logic l3p, logic l3n, logic mon, logic ne, logic nm);
        if (enc != 16'hE706) return 5'b00000;                  // R1
        case (el)
            2'd0: return 5'b00001;                               // R2
            2'd1: if (l2 && ne && nm) return 5'b01000;          // R3
                  else if (l2 && ne) return 5'b00010;           // R4
                  else return 5'b00001;
            2'd2: if (l3p && !l3n && !mon) return 5'b00100;     // R5
                  else return 5'b10000;
            default: return 5'b10000;                            // R6
        endcase
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_req(logic wr, logic [15:0] enc, logic [1:0] el, logic [63:0] wd,
                          logic [5:0] ctl, logic [63:0] cnt, logic off, logic hold);
        logic [4:0] eo;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_enc = enc; req_el = el; req_wdata = wd;
        {l2_enabled, l3_present, l3_narrow, mon_allow, nest_en, nest_mem} = ctl;
        free_count = cnt; offset_off = off;
        eo = exp_out(enc, el, ctl[5], ctl[4], ctl[3], ctl[2], ctl[1], ctl[0]);
        @(negedge clk);
        check("R7 valid", {63'b0, resp_valid}, 64'd1);
        check("R7 outcome", {59'b0, resp_outcome}, {59'b0, eo});
        check("R9 ec", {58'b0, resp_ec}, (eo == 5'b00010 || eo == 5'b00100) ? 64'h18 : 64'h0);
        if (eo != 5'b10000) check("R9 rdata zero", resp_rdata, 64'd0);
        else if (model_known) check("R9 rdata", resp_rdata, model_off);
        check("R3 slot", {52'b0, redir_slot}, (eo == 5'b01000) ? 64'h1A8 : 64'h0);
        check("R3 we", {63'b0, redir_we}, {63'b0, (eo == 5'b01000) && wr});
        check("R3 wdata", redir_wdata, ((eo == 5'b01000) && wr) ? wd : 64'd0);
        if (hold) begin
            // R7: second strobe during response, write of a different value at level 3
            req_write = 1'b1; req_enc = 16'hE706; req_el = 2'd3; req_wdata = ~wd;
        end else req_valid = 1'b0;
        if (eo == 5'b10000 && wr) begin model_off = wd; model_known = 1'b1; end
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 no extra response", {63'b0, resp_valid}, 64'd0);
        if (model_known)
            check("R10 phys", phys_count, off ? cnt : cnt - model_off);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        check("R7 reset valid", {63'b0, resp_valid}, 64'd0);
        check("R7 reset outcome", {59'b0, resp_outcome}, 64'd0);
        rst_n = 1'b1;
        // Directed corners; ctl = {l2,l3p,l3n,mon,ne,nm}
        do_req(1, 16'hE706, 3, 64'h0000_0000_0000_1000, 6'b000000, 64'h5000, 0, 0); // R6 write
        do_req(0, 16'hE706, 3, 0, 6'b000000, 64'h0800, 0, 0);        // R10 wrap below offset
        do_req(0, 16'hE706, 3, 0, 6'b000000, 64'h0800, 1, 0);        // R10 bypass
        do_req(1, 16'hE707, 3, 64'hDEAD, 6'b000000, 64'h9000, 0, 0); // R1 no match, no write
        do_req(1, 16'hE706, 0, 64'hBEEF, 6'b111111, 64'h9000, 0, 0); // R2
        do_req(1, 16'hE706, 1, 64'hCAFE, 6'b100011, 64'h9000, 0, 0); // R3 redirect write
        do_req(0, 16'hE706, 1, 0, 6'b100010, 64'h9000, 0, 0);        // R4 trap
        do_req(1, 16'hE706, 1, 64'h1111, 6'b100001, 64'h9000, 0, 0); // R4 mem bit alone: undef
        do_req(0, 16'hE706, 1, 0, 6'b000011, 64'h9000, 0, 0);        // R4 l2 off: undef
        do_req(1, 16'hE706, 2, 64'h2222, 6'b010000, 64'h9000, 0, 0); // R5 trap3
        do_req(0, 16'hE706, 2, 0, 6'b011000, 64'h9000, 0, 0);        // R5 narrow: access
        do_req(1, 16'hE706, 2, 64'h3333, 6'b010100, 64'h9000, 0, 1); // R8 write + R7 held strobe
        do_req(0, 16'hE706, 3, 0, 6'b000000, 64'h9000, 0, 0);        // R8 readback
        for (int i = 0; i < 300; i++) begin
            logic [15:0] enc;
            enc = ($urandom % 2) ? 16'hE706 : 16'(($urandom % 8) + 16'hE704);
            do_req(1'($urandom), enc, 2'($urandom), {$urandom, $urandom}, 6'($urandom),
                   {$urandom, $urandom}, ($urandom % 8) == 0, 0);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule